// File: doc/BRIEF.md
# MSI Doorbell to Interrupt-Line Translator

This block is a 4 KiB memory-mapped frame that turns message-signalled interrupts into pulses on a bank of shared interrupt lines. A device or bus master writes a global interrupt number to the doorbell register. The block subtracts the first number of its window, which is the base parameter plus 32. If the result falls inside the configured line count, the block raises a single-cycle pulse on the matching output line. Writes that fall outside the window are dropped with no effect.

Software finds the window through two read-only registers. The type register reports the first global number and the line count. The identification register holds a fixed product code. The frame is little-endian and sits on a plain 32-bit register bus with these signals:
- a byte offset
- write data
- an access size in bytes
- single-cycle read and write strobes
- registered read data

The bus has no handshake. Every strobe completes in the cycle it is presented.

Top module: `msi_frame`

## Requirements
- R1: While `rst` is high at a clock edge, `irq_pulse` and `bus_rdata` become all zero from the next cycle on.
- R2: A 4-byte read of offset 0x008 returns ((BASE+32) << 16) | NUM_LINES on `bus_rdata` in the cycle after the read strobe. With the defaults this is 0x0020_0040.
- R3: A 4-byte read of offset 0xFCC returns 0x0510_0000: product code 0x51 in bits [31:20], with the implementer and revision fields zero. Every offset from 0xFD0 to 0xFFC, and every other unmapped offset, reads 0.
- R4: A read whose `bus_size` is not 4 returns 0. Read data updates only on a read strobe and holds its value otherwise.
- R5: A write to offset 0x040 with an accepted size takes bits [9:0] of `bus_wdata` as the interrupt number N. If BASE+32 <= N < BASE+32+NUM_LINES, bit N-(BASE+32) of `irq_pulse` is high for exactly one cycle, in the cycle after the write. Bits [31:10] are ignored.
- R6: A doorbell write whose number is below BASE+32, or at or above BASE+32+NUM_LINES, produces no pulse.
- R7: Doorbell writes are accepted only with `bus_size` 2 or 4. Any other size is dropped and produces no pulse.
- R8: Writes to any offset other than 0x040 have no effect on `irq_pulse` or on any readable register.
- R9: Doorbell writes on consecutive cycles each produce their own one-cycle pulse on their own line, in consecutive cycles. `irq_pulse` never has more than one bit set.
- R10: Elaboration fails if NUM_LINES is 0 or greater than 128, or if BASE+32+NUM_LINES exceeds 1020.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, registered one cycle after the read strobe |
| irq_pulse | output | NUM_LINES | One-hot interrupt pulses, one cycle wide |

## Verification
The assertions take for granted that `bus_rd` and `bus_wr` are never high in the same cycle, and that offsets are compared exactly, so misaligned offsets count as unmapped. They also take the bus inputs to be known values whenever a strobe is high.

The bench drives each access from the falling edge, keeping the two strobes exclusive. It returns the strobes low after every access, except in the deliberate back-to-back doorbell case. It reads results one falling edge later, where the registered output has settled.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned FRAME_AW   = 12;
  localparam int unsigned ID_W       = 10;
  localparam int unsigned SPI_FIRST  = 32;
  localparam int unsigned ID_LIMIT   = 1020;
  localparam int unsigned LINES_MAX  = 128;

  localparam logic [FRAME_AW-1:0] OFS_TYPE  = 12'h008;
  localparam logic [FRAME_AW-1:0] OFS_DOOR  = 12'h040;
  localparam logic [FRAME_AW-1:0] OFS_IDENT = 12'hFCC;

  localparam logic [7:0]  PRODUCT_CODE = 8'h51;
  localparam logic [31:0] IDENT_VAL    = {4'h0, PRODUCT_CODE, 20'h0_0000};
endpackage

// File: rtl/msi_regread.sv
module msi_regread
  import msi_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned BASE      = 0
) (
  input  logic [FRAME_AW-1:0] addr,
  input  logic [2:0]          size,
  output logic [31:0]         value
);
  localparam logic [15:0] FIRST16 = 16'(BASE + SPI_FIRST);
  localparam logic [15:0] COUNT16 = 16'(NUM_LINES);
  localparam logic [31:0] TYPE_VAL = {FIRST16, COUNT16};

  always_comb begin
    value = '0;
    if (size == 3'd4) begin
      unique case (addr)
        OFS_TYPE:  value = TYPE_VAL;
        OFS_IDENT: value = IDENT_VAL;
        default:   value = '0;
      endcase
    end
  end
endmodule

// File: rtl/msi_doorbell.sv
module msi_doorbell
  import msi_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned BASE      = 0,
  localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                wr,
  input  logic [FRAME_AW-1:0] addr,
  input  logic [2:0]          size,
  input  logic [ID_W-1:0]     id,
  output logic                hit,
  output logic [IDX_W-1:0]    idx
);
  localparam logic [ID_W:0] LO_BOUND = (ID_W+1)'(BASE + SPI_FIRST);
  localparam logic [ID_W:0] HI_BOUND = (ID_W+1)'(BASE + SPI_FIRST + NUM_LINES);

  logic            size_ok;
  logic [ID_W:0]   id_ext;
  logic [ID_W:0]   offset;
  logic            in_window;

  always_comb begin
    size_ok   = (size == 3'd2) || (size == 3'd4);
    id_ext    = {1'b0, id};
    offset    = id_ext - LO_BOUND;
    in_window = (id_ext >= LO_BOUND) && (id_ext < HI_BOUND);
    hit       = wr && (addr == OFS_DOOR) && size_ok && in_window;
    idx       = offset[IDX_W-1:0];
  end

  logic unused_hi;
  assign unused_hi = ^offset[ID_W:IDX_W];
endmodule

// File: rtl/msi_pulse_bank.sv
module msi_pulse_bank #(
  parameter int unsigned NUM_LINES = 64,
  localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hit,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_LINES-1:0] pulse
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) pulse[i] <= 1'b0;
      else     pulse[i] <= hit && (idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/msi_frame.sv
module msi_frame
  import msi_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned BASE      = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [2:0]           bus_size,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] irq_pulse
);
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  // R10: configuration limits checked at elaboration
  if (NUM_LINES == 0 || NUM_LINES > LINES_MAX) begin : g_bad_count
    $error("msi_frame: NUM_LINES out of range");
  end
  if (BASE + SPI_FIRST + NUM_LINES > ID_LIMIT) begin : g_bad_window
    $error("msi_frame: interrupt window exceeds ID limit");
  end

  logic [31:0]      rd_val;
  logic             db_hit;
  logic [IDX_W-1:0] db_idx;

  msi_regread #(.NUM_LINES(NUM_LINES), .BASE(BASE)) u_regread (
    .addr  (bus_addr),
    .size  (bus_size),
    .value (rd_val)
  );

  msi_doorbell #(.NUM_LINES(NUM_LINES), .BASE(BASE)) u_doorbell (
    .wr   (bus_wr),
    .addr (bus_addr),
    .size (bus_size),
    .id   (bus_wdata[ID_W-1:0]),
    .hit  (db_hit),
    .idx  (db_idx)
  );

  msi_pulse_bank #(.NUM_LINES(NUM_LINES)) u_pulses (
    .clk   (clk),
    .rst   (rst),
    .hit   (db_hit),
    .idx   (db_idx),
    .pulse (irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[31:ID_W];
endmodule

// File: rtl/msi_frame_chk.sv
module msi_frame_chk
  import msi_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned BASE      = 0
) (
  input logic                 clk,
  input logic                 rst,
  input logic [11:0]          bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [2:0]           bus_size,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] irq_pulse
);
  localparam int unsigned LO = BASE + SPI_FIRST;
  localparam int unsigned HI = BASE + SPI_FIRST + NUM_LINES;
  localparam logic [31:0] TYPE_EXP = 32'(((BASE + SPI_FIRST) << 16) + NUM_LINES);

  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    started && rst |=> (irq_pulse == '0) && (bus_rdata == '0));

  // R2
  type_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_size == 3'd4 && bus_addr == OFS_TYPE |=> bus_rdata == TYPE_EXP);

  // R3
  ident_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_size == 3'd4 && bus_addr == OFS_IDENT |=> bus_rdata == 32'h0510_0000);

  // R4
  narrow_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_size != 3'd4 |=> bus_rdata == '0);

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    started && !bus_rd && !$past(rst) |=> $stable(bus_rdata));

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && (irq_pulse != '0) |->
      $past(bus_wr) && $past(bus_addr) == OFS_DOOR);

  // R6
  window_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && (32'(bus_wdata[9:0]) < LO || 32'(bus_wdata[9:0]) >= HI) |=> irq_pulse == '0);

  // R7
  size_drop_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_size != 3'd2 && bus_size != 3'd4 |=> irq_pulse == '0);

  // R8
  other_offset_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr != OFS_DOOR |=> irq_pulse == '0);

  // R9
  onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_pulse));
endmodule

bind msi_frame msi_frame_chk #(.NUM_LINES(NUM_LINES), .BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_size(bus_size), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
);

// File: tb/msi_frame_bench.sv
module msi_frame_bench;
  localparam int unsigned LINES = 64;
  localparam int unsigned FIRST = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [11:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [2:0]       bus_size = 3'd4;
  logic             bus_rd = 1'b0;
  logic             bus_wr = 1'b0;
  logic [31:0]      bus_rdata;
  logic [LINES-1:0] irq_pulse;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  msi_frame #(.NUM_LINES(LINES), .BASE(0)) u_msi_frame (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LINES-1:0] line_bit(int unsigned id);
    logic [LINES-1:0] v = '0;
    if (id >= FIRST && id < FIRST + LINES) v[id - FIRST] = 1'b1;
    return v;
  endfunction

  task automatic do_read(logic [11:0] a, logic [2:0] sz, logic [31:0] exp, string req);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic do_write(logic [11:0] a, logic [2:0] sz, logic [31:0] d,
                          logic [LINES-1:0] exp, string req);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(req, 64'(irq_pulse), 64'(exp));
    @(negedge clk);
    check({req, " pulse width"}, 64'(irq_pulse), 64'h0);
  endtask

  task automatic t_reset;
    check("R1 pulse after reset", 64'(irq_pulse), 64'h0);
    check("R1 rdata after reset", 64'(bus_rdata), 64'h0);
  endtask

  task automatic t_regs;
    do_read(12'h008, 3'd4, 32'h0020_0040, "R2 type register");
    do_read(12'hFCC, 3'd4, 32'h0510_0000, "R3 ident register");
    do_read(12'hFD0, 3'd4, 32'h0, "R3 id area first");
    do_read(12'hFE8, 3'd4, 32'h0, "R3 peripheral id 2");
    do_read(12'hFFC, 3'd4, 32'h0, "R3 id area last");
    do_read(12'h040, 3'd4, 32'h0, "R3 doorbell reads zero");
    do_read(12'h100, 3'd4, 32'h0, "R3 unmapped offset");
  endtask

  task automatic t_read_size;
    do_read(12'h008, 3'd4, 32'h0020_0040, "R4 setup");
    do_read(12'h008, 3'd2, 32'h0, "R4 2-byte read");
    do_read(12'hFCC, 3'd1, 32'h0, "R4 1-byte read");
    do_read(12'hFCC, 3'd4, 32'h0510_0000, "R4 setup hold");
    @(negedge clk);
    @(negedge clk);
    check("R4 hold without strobe", 64'(bus_rdata), 64'h0510_0000);
  endtask

  task automatic t_doorbell;
    do_write(12'h040, 3'd4, 32'd32, line_bit(32), "R5 first line");
    do_write(12'h040, 3'd4, 32'd95, line_bit(95), "R5 last line");
    do_write(12'h040, 3'd4, 32'd60, line_bit(60), "R5 mid line");
    do_write(12'h040, 3'd4, 32'hFFFF_FC00 | 32'd40, line_bit(40), "R5 upper bits ignored");
  endtask

  task automatic t_window;
    do_write(12'h040, 3'd4, 32'd31, '0, "R6 below window");
    do_write(12'h040, 3'd4, 32'd96, '0, "R6 one past window");
    do_write(12'h040, 3'd4, 32'd1019, '0, "R6 far above window");
  endtask

  task automatic t_sizes;
    do_write(12'h040, 3'd2, 32'd50, line_bit(50), "R7 2-byte accepted");
    do_write(12'h040, 3'd1, 32'd50, '0, "R7 1-byte dropped");
    do_write(12'h040, 3'd0, 32'd50, '0, "R7 size 0 dropped");
  endtask

  task automatic t_other;
    do_write(12'h044, 3'd4, 32'd50, '0, "R8 near offset");
    do_write(12'h008, 3'd4, 32'hDEAD_BEEF, '0, "R8 type write");
    do_read(12'h008, 3'd4, 32'h0020_0040, "R8 type unchanged");
    do_write(12'hFCC, 3'd4, 32'h1234_5678, '0, "R8 ident write");
    do_read(12'hFCC, 3'd4, 32'h0510_0000, "R8 ident unchanged");
  endtask

  task automatic t_back_to_back;
    bus_addr = 12'h040; bus_size = 3'd4; bus_wdata = 32'd33; bus_wr = 1'b1;
    @(negedge clk);
    check("R9 first pulse", 64'(irq_pulse), 64'(line_bit(33)));
    bus_wdata = 32'd90;
    @(negedge clk);
    check("R9 second pulse", 64'(irq_pulse), 64'(line_bit(90)));
    bus_wdata = 32'd33;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 repeat line", 64'(irq_pulse), 64'(line_bit(33)));
    @(negedge clk);
    check("R9 idle after burst", 64'(irq_pulse), 64'h0);
  endtask

  task automatic t_reset_mid;
    bus_addr = 12'h040; bus_size = 3'd4; bus_wdata = 32'd70; bus_wr = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rst = 1'b0;
    check("R1 reset beats doorbell", 64'(irq_pulse), 64'h0);
    check("R1 rdata cleared", 64'(bus_rdata), 64'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_read_size();
    t_doorbell();
    t_window();
    t_sizes();
    t_other();
    t_back_to_back();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule